// File: doc/BRIEF.md
# Timed-Unlock Vector Select Register

This block is a byte-wide control register for a small microcontroller core. It holds a pull-up-disable bit, a vector-table-select bit and a change-enable bit. The select bit decides whether the interrupt vector table starts at the beginning of program memory or at the start of the boot section. To keep a stray store from moving the vector table, the select bit only changes through a two-step sequence. Software first sets the change-enable bit. Then, within a four-cycle window, it writes the new select value with change-enable written as zero.

While the sequence is in progress the block raises an interrupt-mask output, so the interrupt controller holds off interrupts. The global interrupt-enable flag elsewhere in the core is left untouched. After a successful select write, the mask stays up until the instruction after that write has retired. The core signals this with a retire strobe.

The block also turns the boot-reset configuration input and the select bit into the reset address and the interrupt vector base address. Both are used by the fetch logic.

Top module: `vecsel_ctrl`

## Requirements
- R1: After reset, the register reads 0x00, `irq_mask` is 0 and `vec_base` is 0x0001.
- R2: Register bits 7..5 and 3..2 always read zero, and writes to them are ignored. Bit 4 (pull-up disable) is loaded from `wr_data[4]` on every write and drives `pud`.
- R3: A write with `wr_data[0]`=1 sets the change-enable bit. It reads back at bit 0, and `irq_mask` is 1 in the first cycle after that write's clock edge.
- R4: A write with `wr_data[0]`=0 at any of the four clock edges that follow the enabling edge loads `wr_data[1]` into the select bit (read bit 1). It also clears change-enable.
- R5: If no select write arrives, change-enable and `irq_mask` stay high for exactly four cycles after the enabling edge and then fall. The select bit is unchanged.
- R6: A write with `wr_data[0]`=0 while change-enable is clear leaves the select bit unchanged.
- R7: After a select write, `irq_mask` stays 1 until the cycle after the first clock edge that samples `retire`=1 following the write's edge. A `retire` pulse at the write's own edge does not count.
- R8: Writing `wr_data[0]`=1 while the window is open restarts the four-cycle count from that edge.
- R9: `reset_addr` is 0 when `boot_rst_n`=1 (unprogrammed) and `boot_base` when `boot_rst_n`=0.
- R10: `vec_base` is 0x0001 when the select bit is 0 and `boot_base`+1 when it is 1.
- R11: `irq_mask` only rises in a cycle in which change-enable reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| boot_rst_n | input | 1 | Boot-reset configuration, 1 = unprogrammed |
| boot_base | input | AW (16) | Start address of the boot section |
| retire | input | 1 | Instruction-retire strobe |
| reset_addr | output | AW (16) | Reset fetch address |
| vec_base | output | AW (16) | Interrupt vector table base |
| pud | output | 1 | Pull-up disable |
| irq_mask | output | 1 | Automatic interrupt suppress |

## Verification
The bench places the select write on the first and on the fourth edge of the window, and one edge too late. A design with an off-by-one window either misses the fourth-edge write or accepts the late one. It checks that a retire pulse landing on the select write's own edge does not release the mask, since a design that samples retire too early would let interrupts in right after the write. It re-arms change-enable near the end of a window and commits past the original deadline, which catches a counter that is not reloaded. It also writes the select bit with no unlock and expects no change.

// File: rtl/vecsel_pkg.sv
// Package: shared field positions and defaults for the vector select register.
// Assumes an 8-bit register with fixed bit positions decoded by software.
package vecsel_pkg;
    localparam int DATA_W   = 8;
    localparam int BIT_CEN  = 0;
    localparam int BIT_SEL  = 1;
    localparam int BIT_PUD  = 4;
    localparam int DEF_AW   = 16;
    localparam int DEF_WIN  = 4;
endpackage

// File: rtl/vecsel_window.sv
// Module: vecsel_window
// Runs the timed unlock window and the interrupt-mask hold.
// Assumes set_req and sel_req are mutually exclusive (decoded from bit 0).
module vecsel_window #(
    parameter int WIN = vecsel_pkg::DEF_WIN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic sel_req,
    input  logic retire,
    output logic cen,
    output logic commit,
    output logic mask
);
    localparam int CW = $clog2(WIN + 1);

    logic [CW-1:0] cnt_q;
    logic          cen_q;
    logic          hold_q;

    assign commit = cen_q & sel_req;

    // Open, reload, close or expire the change-enable window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cen_q <= 1'b0;
            cnt_q <= '0;
        end else if (set_req) begin
            cen_q <= 1'b1;
            cnt_q <= CW'(WIN);
        end else if (commit) begin
            cen_q <= 1'b0;
            cnt_q <= '0;
        end else if (cen_q) begin
            if (cnt_q <= CW'(1)) begin
                cen_q <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    // Hold the mask from a committed select write until the next retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else if (commit) begin
            hold_q <= 1'b1;
        end else if (hold_q && retire) begin
            hold_q <= 1'b0;
        end
    end

    assign cen  = cen_q;
    assign mask = cen_q | hold_q;
endmodule

// File: rtl/vecsel_regs.sv
// Module: vecsel_regs
// Holds the pull-up-disable and select bits and builds the read value.
// Assumes commit is asserted only for a select write inside the window.
module vecsel_regs (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [vecsel_pkg::DATA_W-1:0]   wr_data,
    input  logic                            commit,
    input  logic                            cen,
    output logic [vecsel_pkg::DATA_W-1:0]   rd_data,
    output logic                            vsel,
    output logic                            pud
);
    import vecsel_pkg::*;

    logic pud_q;
    logic sel_q;

    // Pull-up disable: plain read/write bit.
    always_ff @(posedge clk) begin
        if (!rst_n)     pud_q <= 1'b0;
        else if (wr_en) pud_q <= wr_data[BIT_PUD];
    end

    // Select bit: changes only on a committed select write.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= 1'b0;
        else if (commit) sel_q <= wr_data[BIT_SEL];
    end

    // Read value: reserved positions are forced to zero.
    always_comb begin
        rd_data          = '0;
        rd_data[BIT_PUD] = pud_q;
        rd_data[BIT_SEL] = sel_q;
        rd_data[BIT_CEN] = cen;
    end

    assign vsel = sel_q;
    assign pud  = pud_q;
endmodule

// File: rtl/vecsel_addr.sv
// Module: vecsel_addr
// Computes the reset fetch address and the interrupt vector base.
// Assumes boot_base is static during operation; purely combinational.
module vecsel_addr #(
    parameter int AW = vecsel_pkg::DEF_AW
) (
    input  logic          boot_rst_n,
    input  logic [AW-1:0] boot_base,
    input  logic          vsel,
    output logic [AW-1:0] reset_addr,
    output logic [AW-1:0] vec_base
);
    // Pick reset and vector bases from the configuration and select bit.
    always_comb begin
        reset_addr = boot_rst_n ? '0 : boot_base;
        vec_base   = (vsel ? boot_base : '0) + AW'(1);
    end
endmodule

// File: rtl/vecsel_ctrl.sv
// Module: vecsel_ctrl (top)
// Vector select control register with timed unlock and automatic
// interrupt masking. Assumes one register write per strobe cycle.
module vecsel_ctrl #(
    parameter int AW  = vecsel_pkg::DEF_AW,
    parameter int WIN = vecsel_pkg::DEF_WIN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    output logic [7:0]    rd_data,
    input  logic          boot_rst_n,
    input  logic [AW-1:0] boot_base,
    input  logic          retire,
    output logic [AW-1:0] reset_addr,
    output logic [AW-1:0] vec_base,
    output logic          pud,
    output logic          irq_mask
);
    logic set_req;
    logic sel_req;
    logic cen;
    logic commit;
    logic vsel;

    assign set_req = wr_en &  wr_data[vecsel_pkg::BIT_CEN];
    assign sel_req = wr_en & ~wr_data[vecsel_pkg::BIT_CEN];

    vecsel_window #(.WIN(WIN)) u_win (
        .clk(clk), .rst_n(rst_n), .set_req(set_req), .sel_req(sel_req),
        .retire(retire), .cen(cen), .commit(commit), .mask(irq_mask)
    );

    vecsel_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .commit(commit), .cen(cen), .rd_data(rd_data), .vsel(vsel), .pud(pud)
    );

    vecsel_addr #(.AW(AW)) u_addr (
        .boot_rst_n(boot_rst_n), .boot_base(boot_base), .vsel(vsel),
        .reset_addr(reset_addr), .vec_base(vec_base)
    );
endmodule

// File: rtl/vecsel_chk.sv
// Module: vecsel_chk
// Port-level checker bound to vecsel_ctrl.
module vecsel_chk #(
    parameter int AW  = 16,
    parameter int WIN = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [7:0]    wr_data,
    input logic [7:0]    rd_data,
    input logic [AW-1:0] boot_base,
    input logic [AW-1:0] vec_base,
    input logic          irq_mask
);
    localparam int RW = $clog2(WIN + 2) + 1;
    logic [RW-1:0] run_q;

    // Count consecutive cycles change-enable is seen since the last enabling write.
    always_ff @(posedge clk) begin
        if (!rst_n)                   run_q <= '0;
        else if (wr_en && wr_data[0]) run_q <= RW'(1);
        else if (rd_data[0])          run_q <= run_q + RW'(1);
        else                          run_q <= '0;
    end

    // R5
    window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[0] |-> (run_q <= RW'(WIN)));
    // R6
    sel_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_data[0]) |-> $stable(rd_data[1]));
    // R3
    cen_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[0] |-> irq_mask);
    // R11
    mask_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_mask) |-> rd_data[0]);
    // R10
    vec_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[1] |-> (vec_base == boot_base + AW'(1)));
    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7:5] == 3'b000) && (rd_data[3:2] == 2'b00));
endmodule

bind vecsel_ctrl vecsel_chk #(.AW(AW), .WIN(WIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .boot_base(boot_base), .vec_base(vec_base),
    .irq_mask(irq_mask)
);

// File: tb/sim_vecsel_ctrl.sv
module sim_vecsel_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  rd_data;
    logic        boot_rst_n = 1'b1;
    logic [15:0] boot_base = 16'h3C00;
    logic        retire = 1'b0;
    logic [15:0] reset_addr;
    logic [15:0] vec_base;
    logic        pud;
    logic        irq_mask;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    vecsel_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .boot_rst_n(boot_rst_n), .boot_base(boot_base),
        .retire(retire), .reset_addr(reset_addr), .vec_base(vec_base),
        .pud(pud), .irq_mask(irq_mask)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Caller is at a negedge; the write lands on the next posedge.
    task automatic do_write(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
        chk(irq_mask == 1'b0, "R1 irq_mask", irq_mask, 0);
        chk(vec_base == 16'h0001, "R1 vec_base", vec_base, 1);
    endtask

    task automatic t_pud_reserved;
        do_write(8'hFC);  // bit0=0, select locked
        chk(rd_data == 8'h10, "R2 reserved/pud read", rd_data, 8'h10);
        chk(pud == 1'b1, "R2 pud", pud, 1);
        chk(rd_data[1] == 1'b0, "R6 sel locked", rd_data[1], 0);
        do_write(8'h00);
        chk(pud == 1'b0, "R2 pud clear", pud, 0);
    endtask

    task automatic t_commit_first;
        do_write(8'h01);
        chk(rd_data[0] == 1'b1, "R3 cen set", rd_data[0], 1);
        chk(irq_mask == 1'b1, "R3 mask", irq_mask, 1);
        retire = 1'b1;  // same edge as select write: must not release
        do_write(8'h02);
        retire = 1'b0;
        chk(rd_data[1:0] == 2'b10, "R4 sel set cen clear", rd_data[1:0], 2);
        chk(vec_base == 16'h3C01, "R10 boot vec", vec_base, 16'h3C01);
        chk(irq_mask == 1'b1, "R7 mask held past own-edge retire", irq_mask, 1);
        idle(2);
        chk(irq_mask == 1'b1, "R7 mask held", irq_mask, 1);
        retire = 1'b1; @(negedge clk); retire = 1'b0;
        chk(irq_mask == 1'b0, "R7 mask released", irq_mask, 0);
    endtask

    task automatic t_commit_last;
        do_write(8'h01);
        idle(3);
        do_write(8'h00);  // fourth edge after enabling edge
        chk(rd_data[1] == 1'b0, "R4 fourth-edge commit", rd_data[1], 0);
        chk(vec_base == 16'h0001, "R10 app vec", vec_base, 1);
        retire = 1'b1; @(negedge clk); retire = 1'b0;
    endtask

    task automatic t_timeout;
        do_write(8'h01);
        idle(3);
        chk(irq_mask == 1'b1 && rd_data[0], "R5 still open", irq_mask, 1);
        @(negedge clk);
        chk(irq_mask == 1'b0, "R5 mask expired", irq_mask, 0);
        chk(rd_data[0] == 1'b0, "R5 cen expired", rd_data[0], 0);
        do_write(8'h02);  // too late
        chk(rd_data[1] == 1'b0, "R6 late write ignored", rd_data[1], 0);
    endtask

    task automatic t_restart;
        do_write(8'h01);
        idle(3);
        do_write(8'h01);  // reload at fourth edge
        idle(3);
        chk(rd_data[0] == 1'b1, "R8 window extended", rd_data[0], 1);
        do_write(8'h02);
        chk(rd_data[1] == 1'b1, "R8 commit after restart", rd_data[1], 1);
        retire = 1'b1; @(negedge clk); retire = 1'b0;
    endtask

    task automatic t_addr;
        boot_rst_n = 1'b1; #1;
        chk(reset_addr == 16'h0000, "R9 unprogrammed", reset_addr, 0);
        boot_rst_n = 1'b0; #1;
        chk(reset_addr == 16'h3C00, "R9 programmed", reset_addr, 16'h3C00);
        boot_base = 16'h7000; #1;
        chk(vec_base == 16'h7001, "R10 base tracks", vec_base, 16'h7001);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pud_reserved();
        t_commit_first();
        t_commit_last();
        t_timeout();
        t_restart();
        t_addr();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule